// File: doc/BRIEF.md
# Packed Lane Shift, Compare and Mask Expand Unit

This block performs one lane-parallel operation per clock on a 64-bit packed data word. It can shift two 32-bit lanes or four 16-bit lanes by a single shared count, in arithmetic-right, logical-right or left form. A narrow variant shifts only the two 16-bit lanes of the low 32-bit half.

It also compares four signed 16-bit lanes against a 32-bit second operand and reports the four outcomes as a 4-bit field. Finally, it can spread four mask bits into four 16-bit lanes of all ones or all zeros.

The second operand carries the shift count, the compare data or the mask bits, depending on the opcode. The result is registered, so it appears on the outputs one clock after the inputs are sampled. A datapath that issues one packed operation per cycle can therefore feed the unit back to back.

Top module: `pk_shcmp_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `res` and `cmp_bits` to zero. Outside reset, the outputs show the result of the opcode and operands sampled at the previous rising edge.
- R2: Opcodes 0, 1 and 2 shift each 32-bit lane of `op_a` (lane 0 = bits 31:0) by `op_b[4:0]`: arithmetic right, logical right and left, in that order. Bits 31:5 of `op_b` have no effect.
- R3: Opcodes 3, 4 and 5 shift each of the four 16-bit lanes of `op_a` (lane i = bits 16i+15:16i) by `op_b[3:0]`: arithmetic right, logical right and left, in that order. Bits 31:4 of `op_b` have no effect.
- R4: Opcode 6 shifts the two 16-bit lanes in `op_a[31:0]` left by `op_b[3:0]`. `res[63:32]` is zero.
- R5: Left shifts fill with zeros and discard bits shifted out, with no saturation. Logical right shifts fill with zeros. Arithmetic right shifts fill with the lane's sign bit.
- R6: Opcode 7 sets `cmp_bits[i]` when signed 16-bit lane i of `op_a` is greater than signed lane (i mod 2) of `op_b`. `op_b` lane 0 is bits 15:0 and lane 1 is bits 31:16. `res` holds the field in bits 3:0 and zeros above.
- R7: Opcode 8 sets `cmp_bits[i]` when lane i of `op_a` equals lane (i mod 2) of `op_b`. The lane pairing and the placement in `res` are the same as in R6.
- R8: Opcode 9 sets 16-bit lane i of `res` to 0xFFFF when `op_b[i]` is 1 and to 0x0000 when it is 0. Bits 31:4 of `op_b` have no effect.
- R9: Opcodes 10 to 15 give zero on both outputs. `cmp_bits` is zero after every opcode other than 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Operation select, encoded as listed in the requirements |
| op_a | input | 64 | Packed data operand |
| op_b | input | 32 | Shift count, compare lanes or mask bits |
| res | output | 64 | Registered packed result |
| cmp_bits | output | 4 | Registered compare field, bit i for lane i |

## Verification
The assertions assume that `opcode`, `op_a` and `op_b` are known, non-X values at every rising edge outside reset. They also assume that the inputs do not change near the edge. Several checks compare the outputs against the previous cycle's inputs, so they rely on one operation being presented per cycle with no gaps to bridge.

The stimulus keeps to these assumptions. It changes every input only on the falling edge and drives defined values from the first cycle, including during reset. It also covers shift counts whose ignored upper bits are set, so that the count-masking rules are exercised within those bounds.

// File: rtl/pk_shcmp_pkg.sv
package pk_shcmp_pkg;

    localparam int DATA_W  = 64;
    localparam int SRC2_W  = 32;
    localparam int WIDE_W  = 32;
    localparam int NARR_W  = 16;
    localparam int FLAG_W  = DATA_W / NARR_W;
    localparam int OPC_W   = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_SRA32   = 4'd0,
        OP_SRL32   = 4'd1,
        OP_SLL32   = 4'd2,
        OP_SRA16   = 4'd3,
        OP_SRL16   = 4'd4,
        OP_SLL16   = 4'd5,
        OP_SLL16LO = 4'd6,
        OP_CMPGT   = 4'd7,
        OP_CMPEQ   = 4'd8,
        OP_EXPAND  = 4'd9
    } opcode_e;

    typedef enum logic [1:0] {
        SK_SRA = 2'd0,
        SK_SRL = 2'd1,
        SK_SLL = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [FLAG_W-1:0] flags;
    } unit_out_t;

    function automatic shift_kind_e kind_of(opcode_e op);
        case (op)
            OP_SRA32, OP_SRA16:                  return SK_SRA;
            OP_SRL32, OP_SRL16:                  return SK_SRL;
            default:                             return SK_SLL;
        endcase
    endfunction

    function automatic logic is_wide_shift(opcode_e op);
        return (op == OP_SRA32) || (op == OP_SRL32) || (op == OP_SLL32);
    endfunction

    function automatic logic is_narrow_shift(opcode_e op);
        return (op == OP_SRA16) || (op == OP_SRL16) || (op == OP_SLL16);
    endfunction

endpackage

// File: rtl/pk_lane_shifter.sv
module pk_lane_shifter
    import pk_shcmp_pkg::*;
#(
    parameter int DW = 64,
    parameter int LW = 32
) (
    input  logic [DW-1:0]          din,
    input  logic [$clog2(LW)-1:0]  amt,
    input  shift_kind_e            kind,
    output logic [DW-1:0]          dout
);
    localparam int NLANE = DW / LW;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic signed [LW-1:0] lane_s;
        logic        [LW-1:0] sra_v;
        logic        [LW-1:0] srl_v;
        logic        [LW-1:0] sll_v;

        assign lane_s = din[g*LW +: LW];
        assign sra_v  = lane_s >>> amt;
        assign srl_v  = din[g*LW +: LW] >> amt;
        assign sll_v  = din[g*LW +: LW] << amt;

        always_comb begin
            case (kind)
                SK_SRA:  dout[g*LW +: LW] = sra_v;
                SK_SRL:  dout[g*LW +: LW] = srl_v;
                default: dout[g*LW +: LW] = sll_v;
            endcase
        end
    end
endmodule

// File: rtl/pk_lane_compare.sv
module pk_lane_compare
    import pk_shcmp_pkg::*;
#(
    parameter int DW = 64,
    parameter int BW = 32,
    parameter int LW = 16
) (
    input  logic [DW-1:0]     a,
    input  logic [BW-1:0]     b,
    output logic [DW/LW-1:0]  gt,
    output logic [DW/LW-1:0]  eq
);
    localparam int NLANE = DW / LW;
    localparam int BLANE = BW / LW;

    for (genvar g = 0; g < NLANE; g++) begin : g_cmp
        logic signed [LW-1:0] la;
        logic signed [LW-1:0] lb;

        assign la    = a[g*LW +: LW];
        assign lb    = b[(g % BLANE)*LW +: LW];
        assign gt[g] = la > lb;
        assign eq[g] = la == lb;
    end
endmodule

// File: rtl/pk_mask_expand.sv
module pk_mask_expand #(
    parameter int DW = 64,
    parameter int LW = 16
) (
    input  logic [DW/LW-1:0] mbits,
    output logic [DW-1:0]    lanes
);
    localparam int NLANE = DW / LW;

    for (genvar g = 0; g < NLANE; g++) begin : g_exp
        assign lanes[g*LW +: LW] = {LW{mbits[g]}};
    end
endmodule

// File: rtl/pk_shcmp_unit.sv
module pk_shcmp_unit
    import pk_shcmp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [SRC2_W-1:0]    op_b,
    output logic [DATA_W-1:0]    res,
    output logic [FLAG_W-1:0]    cmp_bits
);
    localparam int WAMT_W = $clog2(WIDE_W);
    localparam int NAMT_W = $clog2(NARR_W);
    localparam int HALF_W = DATA_W / 2;

    opcode_e     op;
    shift_kind_e kind;
    logic [DATA_W-1:0] wide_y;
    logic [DATA_W-1:0] narr_y;
    logic [DATA_W-1:0] exp_y;
    logic [FLAG_W-1:0] gt_v;
    logic [FLAG_W-1:0] eq_v;
    unit_out_t nxt;
    unit_out_t q;

    assign op   = opcode_e'(opcode);
    assign kind = kind_of(op);

    pk_lane_shifter #(.DW(DATA_W), .LW(WIDE_W)) u_wide (
        .din  (op_a),
        .amt  (op_b[WAMT_W-1:0]),
        .kind (kind),
        .dout (wide_y)
    );

    pk_lane_shifter #(.DW(DATA_W), .LW(NARR_W)) u_narr (
        .din  (op_a),
        .amt  (op_b[NAMT_W-1:0]),
        .kind (kind),
        .dout (narr_y)
    );

    pk_lane_compare #(.DW(DATA_W), .BW(SRC2_W), .LW(NARR_W)) u_cmp (
        .a  (op_a),
        .b  (op_b),
        .gt (gt_v),
        .eq (eq_v)
    );

    pk_mask_expand #(.DW(DATA_W), .LW(NARR_W)) u_exp (
        .mbits (op_b[FLAG_W-1:0]),
        .lanes (exp_y)
    );

    always_comb begin
        nxt = '0;
        if (is_wide_shift(op)) begin
            nxt.data = wide_y;
        end else if (is_narrow_shift(op)) begin
            nxt.data = narr_y;
        end else begin
            case (op)
                OP_SLL16LO: nxt.data = {{HALF_W{1'b0}}, narr_y[HALF_W-1:0]};
                OP_CMPGT: begin
                    nxt.flags = gt_v;
                    nxt.data  = {{(DATA_W-FLAG_W){1'b0}}, gt_v};
                end
                OP_CMPEQ: begin
                    nxt.flags = eq_v;
                    nxt.data  = {{(DATA_W-FLAG_W){1'b0}}, eq_v};
                end
                OP_EXPAND:  nxt.data = exp_y;
                default:    nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign res      = q.data;
    assign cmp_bits = q.flags;

    // R1: reset empties both outputs on the following edge
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (res == '0 && cmp_bits == '0));

    // R2: a zero logical-right count passes the operand through
    p_zero_count_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == 4'd1 && $past(op_b[4:0]) == 5'd0)
        |-> res == $past(op_a));

    // R4: the narrow left shift leaves the upper half empty
    p_narrow_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == 4'd6) |-> res[63:32] == '0);

    // R7: equal low lanes must report a set bit 0
    p_eq_lane0_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == 4'd8 && $past(op_a[15:0]) == $past(op_b[15:0]))
        |-> cmp_bits[0]);

    // R8: every lane after an expand is uniform
    p_expand_uniform_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == 4'd9) |->
        ((res[15:0]  == 16'h0 || res[15:0]  == 16'hFFFF) &&
         (res[31:16] == 16'h0 || res[31:16] == 16'hFFFF) &&
         (res[47:32] == 16'h0 || res[47:32] == 16'hFFFF) &&
         (res[63:48] == 16'h0 || res[63:48] == 16'hFFFF)));

    // R9: the compare field is only ever set by a compare opcode
    p_flags_only_cmp_r9: assert property (@(posedge clk) disable iff (rst)
        (cmp_bits != '0) |-> ($past(opcode) == 4'd7 || $past(opcode) == 4'd8));

endmodule

// File: tb/pk_shcmp_unit_bench.sv
module pk_shcmp_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'd0;
    logic [63:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [63:0] res;
    logic [3:0]  cmp_bits;

    int n_cmp = 0;
    int n_bad = 0;

    logic [67:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pk_shcmp_unit u_pk_shcmp_unit (
        .clk(clk), .rst(rst), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .res(res), .cmp_bits(cmp_bits)
    );

    function automatic logic [67:0] model(int op, logic [63:0] a, logic [31:0] b);
        logic [63:0] r = '0;
        logic [3:0]  c = '0;
        logic signed [31:0] t32;
        logic signed [15:0] t16;
        logic signed [15:0] u16;
        int s5 = int'(b[4:0]);
        int s4 = int'(b[3:0]);
        case (op)
            0, 1, 2: for (int k = 0; k < 2; k++) begin
                t32 = a[32*k +: 32];
                if (op == 0)      r[32*k +: 32] = t32 >>> s5;
                else if (op == 1) r[32*k +: 32] = a[32*k +: 32] >> s5;
                else              r[32*k +: 32] = a[32*k +: 32] << s5;
            end
            3, 4, 5: for (int k = 0; k < 4; k++) begin
                t16 = a[16*k +: 16];
                if (op == 3)      r[16*k +: 16] = t16 >>> s4;
                else if (op == 4) r[16*k +: 16] = a[16*k +: 16] >> s4;
                else              r[16*k +: 16] = a[16*k +: 16] << s4;
            end
            6: for (int k = 0; k < 2; k++) r[16*k +: 16] = a[16*k +: 16] << s4;
            7, 8: begin
                for (int k = 0; k < 4; k++) begin
                    t16 = a[16*k +: 16];
                    u16 = b[16*(k%2) +: 16];
                    c[k] = (op == 7) ? (t16 > u16) : (t16 == u16);
                end
                r[3:0] = c;
            end
            9: for (int k = 0; k < 4; k++) r[16*k +: 16] = b[k] ? 16'hFFFF : 16'h0000;
            default: ;
        endcase
        return {r, c};
    endfunction

    task automatic drive(int op, logic [63:0] a, logic [31:0] b, string tag);
        @(negedge clk);
        opcode = 4'(op);
        op_a   = a;
        op_b   = b;
        exp_q.push_back(model(op, a, b));
        tag_q.push_back(tag);
    endtask

    task automatic check_now(logic [67:0] e, string tag);
        n_cmp++;
        if ({res, cmp_bits} !== e) begin
            n_bad++;
            $display("FAIL %s: got res=%h cmp=%h, expected res=%h cmp=%h",
                     tag, res, cmp_bits, e[67:4], e[3:0]);
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check_now(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check_now(68'h0, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        drive(0, 64'h8000_0010_7FFF_FF00, 32'h0000_0004, "R2 R5 sra32");
        drive(0, 64'hF000_0000_1234_5678, 32'hFFFF_FFFF, "R2 sra32 count 31 upper bits ignored");
        drive(1, 64'h8000_0010_7FFF_FF00, 32'hABCD_EF04, "R2 R5 srl32 upper bits ignored");
        drive(1, 64'hDEAD_BEEF_0123_4567, 32'h0000_0000, "R2 srl32 zero count");
        drive(2, 64'hC000_0001_4000_0003, 32'h0000_0001, "R2 R5 sll32 no saturation");
        drive(3, 64'h8000_7FFF_FFF0_0100, 32'h0000_0004, "R3 R5 sra16");
        drive(4, 64'h8000_7FFF_FFF0_0100, 32'hFFFF_FFF4, "R3 R5 srl16 upper bits ignored");
        drive(5, 64'h8001_4000_00FF_1234, 32'h0000_0008, "R3 R5 sll16");
        drive(5, 64'h8001_4000_00FF_1234, 32'h0000_000F, "R3 sll16 count 15");
        drive(6, 64'hFFFF_FFFF_8001_00FF, 32'h0000_0004, "R4 narrow sll");
        drive(7, 64'h0005_8000_7FFF_0003, 32'h0004_0003, "R6 cmpgt mixed");
        drive(7, 64'hFFFF_0001_0000_FFFE, 32'h0000_FFFF, "R6 cmpgt signed");
        drive(8, 64'h1234_5678_1234_5678, 32'h1234_5678, "R7 cmpeq all");
        drive(8, 64'h1234_0000_5678_1234, 32'h1234_5678, "R7 cmpeq partial");
        drive(9, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFF5, "R8 expand upper bits ignored");
        drive(9, 64'h0, 32'h0000_000A, "R8 expand");
        drive(10, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, "R9 undefined opcode 10");
        drive(15, 64'h1234_5678_9ABC_DEF0, 32'h0000_0001, "R9 undefined opcode 15");
        drive(2, 64'h0000_0000_FFFF_FFFF, 32'h0000_001F, "R2 R9 sll32 flags zero");

        for (int i = 0; i < 40; i++) begin
            drive(i % 10, {32'(i * 32'h9E37_79B9), 32'(i * 32'h85EB_CA6B)},
                  32'(i * 32'hC2B2_AE35), "R1 back-to-back stream");
        end

        wait (exp_q.size() == 0);
        @(negedge clk);
        drive(9, 64'h0, 32'h0000_000F, "R8 before reset");
        wait (exp_q.size() == 0);
        @(negedge clk);
        opcode = 4'd9;
        op_b   = 32'hF;
        rst    = 1'b1;
        @(posedge clk);
        #1;
        check_now(68'h0, "R1 reset mid-run");
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule